// File: doc/BRIEF.md
# Center-Aligned Dual-Output PWM Generator

This block is a symmetric PWM timer. A 16-bit time-base counter climbs from zero to a programmed period and then falls back to zero, so one output cycle lasts twice the period value in clock ticks. The period is chosen as the clock rate divided by the wanted output rate, halved.

Two compare channels, A and B, each drive one output pin through an action qualifier. The qualifier raises its pin when the counter meets the channel's compare value on the way up and lowers it when the counter meets the same value on the way down. The result is a pulse centred on the counter peak. Its width is set by the compare value: a duty of d percent maps to compare = period × (100 − d) / 100.

Software programs the block through a single-cycle write port. Period writes land in a shadow register, and the counter adopts them only at zero. Compare writes act at once. A per-channel force bit pins an output low, which is how a channel is stopped. Counting starts only while the global time-base enable is high.

Top module: `updown_pwm`

## Requirements
- R1: After reset the counter reads 0, the direction flag reads up (1), and both outputs are low.
- R2: While `tb_en` is low and no counter write occurs, the counter and direction flag hold their values. On the first clock edge with `tb_en` high, the counter moves one step.
- R3: With period P > 0 the counter steps by one per enabled tick through 0,1,…,P,P−1,…,1,0,1,…, so a full cycle lasts 2P ticks. Each extreme is held for one tick. The direction flag reads 0 (down) at P and on the falling side, and reads 1 (up) at 0 and on the rising side.
- R4: Output A rises on the tick after the counter equals compare A with the flag up. It falls on the tick after the counter equals compare A with the flag down. Otherwise it holds. For 0 < C < P it is high for 2(P−C) ticks per cycle.
- R5: Output B follows the R4 rule independently, using compare B.
- R6: A compare value of 0 keeps its output permanently high once the first match has occurred. A compare value equal to P keeps its output permanently low. Neither case produces any toggle.
- R7: A write to address 0 (period) goes to a shadow register. The running cycle keeps the old period, and the new one governs the counter from the next time it reaches 0.
- R8: Address 5 holds the force bits: bit 0 for A and bit 1 for B. A set bit drives that output low from the next tick for as long as it stays set. After the bit is cleared, the output stays low until the next qualified event.
- R9: A write to address 1 (phase) is accepted and discarded. Phase loading is off, and the write never disturbs the counter.
- R10: A write to address 2 loads the counter with the written value on the next edge, whether or not the block is enabled.
- R11: Writes to address 3 (compare A) and address 4 (compare B) take effect on the next tick without waiting for a counter event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | Global time-base enable; counter runs while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1 phase, 2 counter, 3 compare A, 4 compare B, 5 force) |
| wr_data | input | CW | Write data |
| cnt_o | output | CW | Time-base counter value |
| cnt_up_o | output | 1 | Direction flag, 1 = counting up |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
The bench builds the block with the default 16-bit counter width and programs the short periods 4, 6 and 20. With these periods every turnaround, every shadow reload at zero and both compare extremes (0 and P) come round within a few dozen ticks. The forced-low and release sequences also fit in a handful of full cycles. The period of 20 lets the duty formula produce a non-trivial compare value (15 for 25 %), whose pulse width is checked against 2(P−C).

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;

  localparam int NCH = 2;

  typedef enum logic [2:0] {
    REG_PERIOD = 3'd0,
    REG_PHASE  = 3'd1,
    REG_COUNT  = 3'd2,
    REG_CMP_A  = 3'd3,
    REG_CMP_B  = 3'd4,
    REG_FORCE  = 3'd5
  } reg_addr_e;

endpackage

// File: rtl/updown_pwm_regs.sv
module updown_pwm_regs
  import updown_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [CW-1:0]            wr_data,
  output logic [CW-1:0]            prd_shd,
  output logic [NCH-1:0][CW-1:0]   cmp,
  output logic [NCH-1:0]           force_low,
  output logic                     cnt_ld,
  output logic [CW-1:0]            cnt_ld_val
);

  logic [CW-1:0]          prd_q;
  logic [NCH-1:0][CW-1:0] cmp_q;
  logic [NCH-1:0]         force_q;

  // counter load is a pass-through strobe to the time base
  assign cnt_ld     = wr_en && (wr_addr == REG_COUNT);
  assign cnt_ld_val = wr_data;

  // phase writes (REG_PHASE) are decoded nowhere: loading is disabled

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_q   <= '0;
      force_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_PERIOD) prd_q   <= wr_data;
      if (wr_addr == REG_FORCE)  force_q <= wr_data[NCH-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    localparam logic [2:0] CMP_ADDR = 3'(int'(REG_CMP_A) + g);
    always_ff @(posedge clk) begin
      if (rst)                               cmp_q[g] <= '0;
      else if (wr_en && wr_addr == CMP_ADDR) cmp_q[g] <= wr_data;
    end
  end

  assign prd_shd   = prd_q;
  assign cmp       = cmp_q;
  assign force_low = force_q;

endmodule

// File: rtl/updown_pwm_timebase.sv
module updown_pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] prd_shd,
  output logic [CW-1:0] cnt,
  output logic          up
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, prd_q, prd_eff, cnt_nxt;
  logic          up_q, up_nxt, at_zero;

  assign at_zero = (cnt_q == '0);
  // at zero the shadow is the period in force for the step leaving zero
  assign prd_eff = at_zero ? prd_shd : prd_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (up_q) begin
      if (cnt_q < prd_eff) cnt_nxt = cnt_q + ONE;
      else if (!at_zero)   cnt_nxt = cnt_q - ONE;
    end else begin
      if (!at_zero)             cnt_nxt = cnt_q - ONE;
      else if (prd_eff != '0)   cnt_nxt = ONE;
    end

    if (cnt_nxt == '0)           up_nxt = 1'b1;
    else if (cnt_nxt >= prd_eff) up_nxt = 1'b0;
    else                         up_nxt = (cnt_nxt > cnt_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      prd_q <= '0;
    end else begin
      if (at_zero) prd_q <= prd_shd;
      if (ld) begin
        cnt_q <= ld_val;
      end else if (en) begin
        cnt_q <= cnt_nxt;
        up_q  <= up_nxt;
      end
    end
  end

  assign cnt = cnt_q;
  assign up  = up_q;

endmodule

// File: rtl/updown_pwm_action.sv
module updown_pwm_action #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic          up,
  input  logic [CW-1:0] cmp,
  input  logic          force_low,
  output logic          pwm
);

  logic pwm_q;
  logic hit;

  assign hit = en && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst)            pwm_q <= 1'b0;
    else if (force_low) pwm_q <= 1'b0;
    else if (hit)       pwm_q <= up;
  end

  assign pwm = pwm_q;

endmodule

// File: rtl/updown_pwm.sv
module updown_pwm
  import updown_pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tb_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_up_o,
  output logic          pwm_a,
  output logic          pwm_b
);

  logic [CW-1:0]          prd_shd_w;
  logic [NCH-1:0][CW-1:0] cmp_w;
  logic [NCH-1:0]         force_w;
  logic                   cnt_ld_w;
  logic [CW-1:0]          cnt_ld_val_w;
  logic [CW-1:0]          cnt_w;
  logic                   up_w;
  logic [NCH-1:0]         pwm_w;

  updown_pwm_regs #(.CW(CW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prd_shd    (prd_shd_w),
    .cmp        (cmp_w),
    .force_low  (force_w),
    .cnt_ld     (cnt_ld_w),
    .cnt_ld_val (cnt_ld_val_w)
  );

  updown_pwm_timebase #(.CW(CW)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .en      (tb_en),
    .ld      (cnt_ld_w),
    .ld_val  (cnt_ld_val_w),
    .prd_shd (prd_shd_w),
    .cnt     (cnt_w),
    .up      (up_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    updown_pwm_action #(.CW(CW)) u_aq (
      .clk       (clk),
      .rst       (rst),
      .en        (tb_en),
      .cnt       (cnt_w),
      .up        (up_w),
      .cmp       (cmp_w[g]),
      .force_low (force_w[g]),
      .pwm       (pwm_w[g])
    );
  end

  assign cnt_o    = cnt_w;
  assign cnt_up_o = up_w;
  assign pwm_a    = pwm_w[0];
  assign pwm_b    = pwm_w[1];

endmodule

// File: rtl/updown_pwm_chk.sv
module updown_pwm_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tb_en,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [CW-1:0] cnt,
  input logic          up,
  input logic [CW-1:0] cmp_a,
  input logic [CW-1:0] cmp_b,
  input logic [1:0]    force_low,
  input logic          pwm_a,
  input logic          pwm_b
);

  logic ld;
  assign ld = wr_en && (wr_addr == 3'd2);

  assert_held_R2: assert property (@(posedge clk) disable iff (rst)
    (!tb_en && !ld) |=> ($stable(cnt) && $stable(up)));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tb_en && !ld) |=> (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1 || cnt == $past(cnt)));

  assert_bottom_R3: assert property (@(posedge clk) disable iff (rst)
    (tb_en && !ld && !up && cnt == 1) |=> (cnt == 0 && up));

  assert_set_a_R4: assert property (@(posedge clk) disable iff (rst)
    (tb_en && up && cnt == cmp_a && !force_low[0]) |=> pwm_a);

  assert_clr_a_R4: assert property (@(posedge clk) disable iff (rst)
    (tb_en && !up && cnt == cmp_a) |=> !pwm_a);

  assert_set_b_R5: assert property (@(posedge clk) disable iff (rst)
    (tb_en && up && cnt == cmp_b && !force_low[1]) |=> pwm_b);

  assert_clr_b_R5: assert property (@(posedge clk) disable iff (rst)
    (tb_en && !up && cnt == cmp_b) |=> !pwm_b);

  assert_force_a_R8: assert property (@(posedge clk) disable iff (rst)
    force_low[0] |=> !pwm_a);

  assert_force_b_R8: assert property (@(posedge clk) disable iff (rst)
    force_low[1] |=> !pwm_b);

endmodule

bind updown_pwm updown_pwm_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tb_en     (tb_en),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .cnt       (cnt_o),
  .up        (cnt_up_o),
  .cmp_a     (cmp_w[0]),
  .cmp_b     (cmp_w[1]),
  .force_low (force_w),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b)
);

// File: tb/updown_pwm_bench.sv
module updown_pwm_bench;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tb_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] cnt_o;
  logic          cnt_up_o, pwm_a, pwm_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  updown_pwm #(.CW(CW)) u_updown_pwm (
    .clk(clk), .rst(rst), .tb_en(tb_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .cnt_up_o(cnt_up_o), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = CW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_zero();
    for (int i = 0; i < 200; i++) begin
      if (cnt_o == 0) break;
      @(negedge clk);
    end
  endtask

  // follow both outputs for n ticks using the set-on-up / clear-on-down rule
  task automatic follow(input int n, input int ca, input int cb, input bit fa, input bit fb,
                        input string ta, input string tb, output int hi_a, output int hi_b);
    int pc; bit pu, pa, pb, ea, eb;
    hi_a = 0; hi_b = 0;
    for (int k = 0; k < n; k++) begin
      pc = int'(cnt_o); pu = cnt_up_o; pa = pwm_a; pb = pwm_b;
      @(negedge clk);
      ea = fa ? 1'b0 : (pc == ca) ? pu : pa;
      eb = fb ? 1'b0 : (pc == cb) ? pu : pb;
      chk(pwm_a == ea, ta, int'(pwm_a), int'(ea));
      chk(pwm_b == eb, tb, int'(pwm_b), int'(eb));
      hi_a += int'(pwm_a); hi_b += int'(pwm_b);
    end
  endtask

  task automatic t_reset();
    tick(1);
    chk(cnt_o == 0, "R1 count", int'(cnt_o), 0);
    chk(cnt_up_o == 1, "R1 dir", int'(cnt_up_o), 1);
    chk(pwm_a == 0 && pwm_b == 0, "R1 outputs", int'({pwm_a, pwm_b}), 0);
  endtask

  task automatic t_idle();
    wr(2, 3);
    chk(cnt_o == 3, "R10 counter write", int'(cnt_o), 3);
    tick(4);
    chk(cnt_o == 3, "R2 held", int'(cnt_o), 3);
    chk(pwm_a == 0 && pwm_b == 0, "R2 outputs idle", int'({pwm_a, pwm_b}), 0);
    wr(1, 9);
    chk(cnt_o == 3, "R9 phase write ignored", int'(cnt_o), 3);
    tick(2);
    chk(cnt_o == 3, "R9 phase no late effect", int'(cnt_o), 3);
    wr(2, 0);
    chk(cnt_o == 0, "R10 counter clear", int'(cnt_o), 0);
  endtask

  task automatic t_triangle();
    int ha, hb;
    wr(0, 4); wr(3, 1); wr(4, 3);
    @(negedge clk) tb_en = 1'b1;
    for (int k = 1; k <= 24; k++) begin
      int m, e; bit eu;
      @(negedge clk);
      m = k % 8; e = (m <= 4) ? m : 8 - m; eu = (m < 4);
      chk(int'(cnt_o) == e, "R3 count", int'(cnt_o), e);
      chk(cnt_up_o == eu, "R3 dir", int'(cnt_up_o), int'(eu));
    end
    follow(8, 1, 3, 0, 0, "R4 edge", "R5 edge", ha, hb);
    chk(ha == 6, "R4 width", ha, 6);
    chk(hb == 2, "R5 width", hb, 2);
  endtask

  task automatic t_shadow();
    int mx, steps;
    for (int i = 0; i < 20; i++) begin
      if (cnt_o == 2 && cnt_up_o) break;
      @(negedge clk);
    end
    wr(0, 6);
    mx = int'(cnt_o);
    for (int i = 0; i < 50 && cnt_o != 0; i++) begin
      @(negedge clk);
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
    end
    chk(mx == 4, "R7 old period kept", mx, 4);
    mx = 0; steps = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); steps++;
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
      if (cnt_o == 0) break;
    end
    chk(mx == 6, "R7 new peak", mx, 6);
    chk(steps == 12, "R7 new cycle length", steps, 12);
  endtask

  task automatic t_extremes();
    int ha, hb;
    wr(3, 0); wr(4, 6);
    tick(14);
    follow(12, 0, 6, 0, 0, "R6 edge A", "R6 edge B", ha, hb);
    chk(ha == 12, "R6 compare zero high", ha, 12);
    chk(hb == 0, "R6 compare period low", hb, 0);
  endtask

  task automatic t_immediate();
    int ha, hb;
    wr(3, 4); wr(4, 2);
    follow(12, 4, 2, 0, 0, "R11 edge A", "R11 edge B", ha, hb);
    follow(12, 4, 2, 0, 0, "R4 edge", "R5 edge", ha, hb);
    chk(ha == 4, "R11 new width A", ha, 4);
    chk(hb == 8, "R11 new width B", hb, 8);
  endtask

  task automatic t_force();
    int ha, hb;
    wr(5, 1);
    follow(12, 4, 2, 1, 0, "R8 force A", "R8 B free", ha, hb);
    chk(ha == 0, "R8 A held low", ha, 0);
    chk(hb == 8, "R8 B unaffected", hb, 8);
    wr(5, 0);
    follow(24, 4, 2, 0, 0, "R8 release A", "R8 release B", ha, hb);
    wr(5, 2);
    follow(12, 4, 2, 0, 1, "R8 A free", "R8 force B", ha, hb);
    chk(hb == 0, "R8 B held low", hb, 0);
    chk(ha == 4, "R8 A unaffected", ha, 4);
    wr(5, 0);
  endtask

  task automatic t_pause();
    logic [CW-1:0] c0; logic pa, pb;
    @(negedge clk) tb_en = 1'b0;
    c0 = cnt_o; pa = pwm_a; pb = pwm_b;
    tick(6);
    chk(cnt_o == c0, "R2 paused count", int'(cnt_o), int'(c0));
    chk(pwm_a == pa && pwm_b == pb, "R2 paused outputs", int'({pwm_a, pwm_b}), int'({pa, pb}));
    tb_en = 1'b1;
    @(negedge clk);
    chk(cnt_o != c0, "R2 restart first edge", int'(cnt_o), int'(c0) + 1);
  endtask

  task automatic t_duty();
    int ha, hb, c;
    wr(0, 20);
    wait_zero();
    tick(2);
    c = 20 * (100 - 25) / 100;
    wr(3, c);
    tick(44);
    follow(40, c, 2, 0, 0, "R4 edge", "R5 edge", ha, hb);
    chk(ha == 10, "R4 duty 25 width", ha, 10);
    chk(hb == 36, "R5 width period 20", hb, 36);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_triangle();
    t_shadow();
    t_extremes();
    t_immediate();
    t_force();
    t_pause();
    t_duty();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule